// File: doc/BRIEF.md
# Multi-Lane Stream Rule Monitor

A passive observer for a valid/ready stream whose transfers carry several element lanes, plus side information: a start lane index, an end lane index, a per-lane strobe, and a termination vector holding one bit per nesting level for every lane. A complexity level, fixed at elaboration, decides how much freedom the source has when it places elements in lanes and marks sequence ends. The lower the level, the more rules apply. The monitor never drives the stream. It only watches accepted handshakes.

Each rule has its own error flag. A flag is set by the first accepted transfer that breaks the rule and stays set until reset. A combined error output is the OR of all flags. Two counters track accepted transfers and transfers that close an innermost sequence. The block tracks whether a sequence is open, meaning data has been accepted since the last innermost termination. It uses this to tell a legal empty sequence apart from a termination that was put off onto an idle transfer.

Lane count, nesting depth and complexity are parameters. A side signal that a given parameter set leaves out is given its implied value: start index 0, end index lanes−1, or every strobe high. The input pin for it is then ignored.

Top module: `stream_lane_monitor`

## Requirements
- R1: Rules are evaluated, flags are set and counters advance only on cycles where `s_valid` and `s_ready` are both high; any other cycle changes none of them.
- R2: Synchronous active-low reset clears all flags, both counters and the open-sequence state. A set flag stays set until reset. `err_any` is high exactly when some flag is set. Flags become visible in the cycle after the handshake.
- R3: Flag bit 0 (short fill): with complexity below 5 and more than one lane, an active transfer that has no termination bit set anywhere and whose end index is not lanes−1.
- R4: Flag bit 1 (mixed strobe): with complexity below 8, more than one lane and a strobe present, the strobe bits are not all equal.
- R5: Flag bit 2 (early-lane termination): with complexity below 8, more than one lane and depth at least 1, a termination bit is set in any lane other than the last one. Termination bit for lane i, level j sits at `s_last[i*DIMS+j]`.
- R6: Flag bit 3 (level order): with complexity below 4 and depth at least 2, some lane has a termination bit set at level j while a lower level's bit is clear. This is exempt when the transfer is an empty sequence, meaning an inactive transfer with no open sequence.
- R7: Flag bit 4 (postponed termination): with complexity below 4 and depth at least 1, an inactive transfer sets a level-0 termination bit while a sequence is open.
- R8: Flag bit 5 (index range): with an end index present, an active transfer has an end index of lanes or more, or a start index above the end index.
- R9: A transfer is active when any effective strobe bit is high. On an inactive transfer, the start and end indices are ignored, so neither bit 0 nor bit 5 can be set.
- R10: An omitted side signal takes its implied value and its pin is ignored. The start index exists only at complexity ≥6 with more than one lane. The end index exists only when (complexity ≥5 or depth ≥1) and there is more than one lane. The strobe exists only at complexity ≥7 or depth ≥1.
- R11: `xfer_count` adds one per accepted transfer. `term_count` adds one per accepted transfer with at least one level-0 termination bit set in any lane. Both wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Source has a transfer |
| s_ready | input | 1 | Sink accepts the transfer |
| s_stai | input | IDX_W | First active lane index |
| s_endi | input | IDX_W | Last active lane index |
| s_strb | input | LANES | Per-lane strobe |
| s_last | input | LANES*DIMS | Termination bits, lane-major |
| err_flags | output | 6 | Sticky per-rule error flags |
| err_any | output | 1 | OR of all flags |
| xfer_count | output | CNT_W | Accepted transfers |
| term_count | output | CNT_W | Transfers closing an innermost sequence |

## Verification
The bench builds the monitor with three lanes, depth two and complexity three. At complexity below four, every rule that depends on the level is active. At depth two, the level-order rule and the empty outer sequence can both be exercised. With three lanes, a two-bit end index can hold the value 3, so the out-of-range case can be driven. At this complexity the start index is omitted, which lets the bench show that its pin is ignored. The start-above-end comparison cannot be reached with these parameters.

// File: rtl/slm_pkg.sv
// Shared constants for the stream lane monitor.
// Assumes: flag positions below are part of the block's visible interface.
package slm_pkg;
    localparam int NUM_RULES    = 6;
    localparam int RULE_SHORT   = 0;
    localparam int RULE_STRB    = 1;
    localparam int RULE_LANE    = 2;
    localparam int RULE_ORDER   = 3;
    localparam int RULE_POSTP   = 4;
    localparam int RULE_RANGE   = 5;

    // Start index is carried only at high complexity with several lanes.
    function automatic bit has_stai(int cplx, int lanes);
        return (cplx >= 6) && (lanes > 1);
    endfunction

    // End index is carried when lanes can be partly filled.
    function automatic bit has_endi(int cplx, int dims, int lanes);
        return ((cplx >= 5) || (dims >= 1)) && (lanes > 1);
    endfunction

    // Strobe is carried when per-lane activity or empty sequences exist.
    function automatic bit has_strb(int cplx, int dims);
        return (cplx >= 7) || (dims >= 1);
    endfunction
endpackage

// File: rtl/slm_field_view.sv
// Resolves the side signals into their effective values, replacing
// each omitted signal by its implied value, and derives activity and
// termination summaries.
// Assumes: termination bits are lane-major, lane i level j at i*DIMS+j.
module slm_field_view
    import slm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DIMS   = 2,
    parameter int CPLX   = 3,
    parameter int IDX_W  = 2,
    parameter int LAST_W = 8
) (
    input  logic [IDX_W-1:0]  stai,
    input  logic [IDX_W-1:0]  endi,
    input  logic [LANES-1:0]  strb,
    input  logic [LAST_W-1:0] last,
    output logic [IDX_W-1:0]  eff_stai,
    output logic [IDX_W-1:0]  eff_endi,
    output logic [LANES-1:0]  eff_strb,
    output logic              active,
    output logic              any_dim0,
    output logic              last_any
);
    localparam bit HAS_STAI = has_stai(CPLX, LANES);
    localparam bit HAS_ENDI = has_endi(CPLX, DIMS, LANES);
    localparam bit HAS_STRB = has_strb(CPLX, DIMS);

    generate
        if (HAS_STAI) begin : g_stai
            assign eff_stai = stai;
        end else begin : g_no_stai
            logic unused_stai;
            assign unused_stai = ^stai;
            assign eff_stai    = '0;
        end

        if (HAS_ENDI) begin : g_endi
            assign eff_endi = endi;
        end else begin : g_no_endi
            logic unused_endi;
            assign unused_endi = ^endi;
            assign eff_endi    = IDX_W'(LANES - 1);
        end

        if (HAS_STRB) begin : g_strb
            assign eff_strb = strb;
        end else begin : g_no_strb
            logic unused_strb;
            assign unused_strb = ^strb;
            assign eff_strb    = '1;
        end

        if (DIMS > 0) begin : g_dims
            // Collect level-0 termination across lanes.
            always_comb begin
                any_dim0 = 1'b0;
                for (int i = 0; i < LANES; i++) begin
                    any_dim0 = any_dim0 | last[i*DIMS];
                end
            end
            assign last_any = |last;
        end else begin : g_no_dims
            logic unused_last;
            assign unused_last = ^last;
            assign any_dim0    = 1'b0;
            assign last_any    = 1'b0;
        end
    endgenerate

    assign active = |eff_strb;
endmodule

// File: rtl/slm_rule_eval.sv
// Combinational rule evaluation for one transfer. Each rule is built
// only when the parameters make it apply; otherwise its bit is tied low.
// Assumes: inputs are effective values from slm_field_view.
module slm_rule_eval
    import slm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DIMS   = 2,
    parameter int CPLX   = 3,
    parameter int IDX_W  = 2,
    parameter int LAST_W = 8
) (
    input  logic [IDX_W-1:0]     eff_stai,
    input  logic [IDX_W-1:0]     eff_endi,
    input  logic [LANES-1:0]     eff_strb,
    input  logic                 active,
    input  logic [LAST_W-1:0]    last,
    input  logic                 last_any,
    input  logic                 any_dim0,
    input  logic                 open_seq,
    output logic [NUM_RULES-1:0] viol
);
    localparam bit HAS_ENDI = has_endi(CPLX, DIMS, LANES);
    localparam bit HAS_STRB = has_strb(CPLX, DIMS);
    localparam logic [IDX_W:0] LAST_IDX  = (IDX_W+1)'(LANES - 1);
    localparam logic [IDX_W:0] LANE_LIM  = (IDX_W+1)'(LANES);

    logic unused_in;
    assign unused_in = ^{eff_stai, eff_endi, eff_strb, last, last_any, any_dim0};

    logic empty_seq;
    assign empty_seq = !active && !open_seq;

    generate
        if ((CPLX < 5) && HAS_ENDI) begin : g_short
            assign viol[RULE_SHORT] = active && !last_any &&
                                      ({1'b0, eff_endi} != LAST_IDX);
        end else begin : g_no_short
            assign viol[RULE_SHORT] = 1'b0;
        end

        if ((CPLX < 8) && HAS_STRB && (LANES > 1)) begin : g_strb
            assign viol[RULE_STRB] = (|eff_strb) && !(&eff_strb);
        end else begin : g_no_strb
            assign viol[RULE_STRB] = 1'b0;
        end

        if ((CPLX < 8) && (LANES > 1) && (DIMS >= 1)) begin : g_lane
            assign viol[RULE_LANE] = |last[(LANES-1)*DIMS-1:0];
        end else begin : g_no_lane
            assign viol[RULE_LANE] = 1'b0;
        end

        if ((CPLX < 4) && (DIMS >= 2)) begin : g_order
            logic bad_order;
            // Scan each lane for a level set above a clear lower level.
            always_comb begin
                bad_order = 1'b0;
                for (int i = 0; i < LANES; i++) begin
                    logic low_all;
                    low_all = last[i*DIMS];
                    for (int j = 1; j < DIMS; j++) begin
                        bad_order = bad_order | (last[i*DIMS+j] & !low_all);
                        low_all   = low_all & last[i*DIMS+j];
                    end
                end
            end
            assign viol[RULE_ORDER] = bad_order && !empty_seq;
        end else begin : g_no_order
            assign viol[RULE_ORDER] = 1'b0;
        end

        if ((CPLX < 4) && (DIMS >= 1)) begin : g_postp
            assign viol[RULE_POSTP] = !active && any_dim0 && open_seq;
        end else begin : g_no_postp
            assign viol[RULE_POSTP] = 1'b0;
        end

        if (HAS_ENDI) begin : g_range
            assign viol[RULE_RANGE] = active &&
                (({1'b0, eff_endi} >= LANE_LIM) || (eff_stai > eff_endi));
        end else begin : g_no_range
            assign viol[RULE_RANGE] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/slm_tracker.sv
// Tracks whether a sequence is open and counts accepted transfers and
// innermost terminations.
// Assumes: fire marks an accepted handshake; counters wrap.
module slm_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             active,
    input  logic             any_dim0,
    output logic             open_seq,
    output logic [CNT_W-1:0] xfer_count,
    output logic [CNT_W-1:0] term_count
);
    // Open-sequence state: set by data, cleared by level-0 termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_seq <= 1'b0;
        end else if (fire) begin
            if (any_dim0) begin
                open_seq <= 1'b0;
            end else if (active) begin
                open_seq <= 1'b1;
            end
        end
    end

    // Transfer and termination counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_count <= '0;
            term_count <= '0;
        end else if (fire) begin
            xfer_count <= xfer_count + 1'b1;
            if (any_dim0) begin
                term_count <= term_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_lane_monitor.sv
// Top of the stream lane monitor: resolves side signals, evaluates the
// complexity-dependent rules on each accepted handshake and keeps sticky
// per-rule flags.
// Assumes: the monitor is passive; it never drives s_ready.
module stream_lane_monitor
    import slm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DIMS   = 2,
    parameter int CPLX   = 3,
    parameter int CNT_W  = 16,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int LAST_W = (DIMS > 0) ? LANES * DIMS : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic                 s_ready,
    input  logic [IDX_W-1:0]     s_stai,
    input  logic [IDX_W-1:0]     s_endi,
    input  logic [LANES-1:0]     s_strb,
    input  logic [LAST_W-1:0]    s_last,
    output logic [NUM_RULES-1:0] err_flags,
    output logic                 err_any,
    output logic [CNT_W-1:0]     xfer_count,
    output logic [CNT_W-1:0]     term_count
);
    logic                 fire;
    logic [IDX_W-1:0]     eff_stai;
    logic [IDX_W-1:0]     eff_endi;
    logic [LANES-1:0]     eff_strb;
    logic                 active;
    logic                 any_dim0;
    logic                 last_any;
    logic                 open_seq;
    logic [NUM_RULES-1:0] viol;

    assign fire = s_valid && s_ready;

    slm_field_view #(
        .LANES(LANES), .DIMS(DIMS), .CPLX(CPLX), .IDX_W(IDX_W), .LAST_W(LAST_W)
    ) u_view (
        .stai(s_stai), .endi(s_endi), .strb(s_strb), .last(s_last),
        .eff_stai(eff_stai), .eff_endi(eff_endi), .eff_strb(eff_strb),
        .active(active), .any_dim0(any_dim0), .last_any(last_any)
    );

    slm_rule_eval #(
        .LANES(LANES), .DIMS(DIMS), .CPLX(CPLX), .IDX_W(IDX_W), .LAST_W(LAST_W)
    ) u_rules (
        .eff_stai(eff_stai), .eff_endi(eff_endi), .eff_strb(eff_strb),
        .active(active), .last(s_last), .last_any(last_any),
        .any_dim0(any_dim0), .open_seq(open_seq), .viol(viol)
    );

    slm_tracker #(
        .CNT_W(CNT_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .fire(fire), .active(active),
        .any_dim0(any_dim0), .open_seq(open_seq),
        .xfer_count(xfer_count), .term_count(term_count)
    );

    // Sticky error flags, accumulated on accepted handshakes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags <= '0;
        end else if (fire) begin
            err_flags <= err_flags | viol;
        end
    end

    assign err_any = |err_flags;
endmodule

// File: rtl/slm_monitor_sva.sv
// Temporal checks for stream_lane_monitor, attached by bind.
// Assumes: flag positions from slm_pkg.
module slm_monitor_sva
    import slm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DIMS   = 2,
    parameter int CPLX   = 3,
    parameter int CNT_W  = 16,
    parameter int LAST_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 s_valid,
    input logic                 s_ready,
    input logic [LANES-1:0]     s_strb,
    input logic [LAST_W-1:0]    s_last,
    input logic [NUM_RULES-1:0] err_flags,
    input logic                 err_any,
    input logic [CNT_W-1:0]     xfer_count,
    input logic [CNT_W-1:0]     term_count
);
    logic unused_chk;
    assign unused_chk = ^{s_last, err_any};

    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> err_flags == $past(err_flags)); // R1

    AST_IDLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> $stable(xfer_count) && $stable(term_count)); // R1

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != '0) |=> (err_flags & $past(err_flags)) == $past(err_flags)); // R2

    AST_XFER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> xfer_count == $past(xfer_count) + 1'b1); // R11

    AST_TERM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (term_count - $past(term_count)) <= 1); // R11

    generate
        if ((CPLX < 8) && has_strb(CPLX, DIMS) && (LANES > 1)) begin : g_strb_chk
            AST_STRB_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
                (s_valid && s_ready && (|s_strb) && !(&s_strb))
                |=> err_flags[RULE_STRB]); // R4
        end
    endgenerate
endmodule

bind stream_lane_monitor slm_monitor_sva #(
    .LANES(LANES), .DIMS(DIMS), .CPLX(CPLX), .CNT_W(CNT_W), .LAST_W(LAST_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_strb(s_strb), .s_last(s_last), .err_flags(err_flags),
    .err_any(err_any), .xfer_count(xfer_count), .term_count(term_count)
);

// File: tb/stream_lane_monitor_tb.sv
// Bench: three lanes, depth two, complexity three.
module stream_lane_monitor_tb_top;
    localparam int LANES = 3;
    localparam int DIMS  = 2;
    localparam int CPLX  = 3;
    localparam int CNT_W = 8;
    localparam int NV    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready = 1'b0;
    logic [1:0] s_stai = '0;
    logic [1:0] s_endi = '0;
    logic [2:0] s_strb = '0;
    logic [5:0] s_last = '0;
    logic [5:0] err_flags;
    logic       err_any;
    logic [CNT_W-1:0] xfer_count;
    logic [CNT_W-1:0] term_count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stream_lane_monitor #(
        .LANES(LANES), .DIMS(DIMS), .CPLX(CPLX), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_stai(s_stai), .s_endi(s_endi), .s_strb(s_strb), .s_last(s_last),
        .err_flags(err_flags), .err_any(err_any),
        .xfer_count(xfer_count), .term_count(term_count)
    );

    // {open_first, stai, endi, strb, last, expected flags}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'd0, 2'd2, 3'b111, 6'b000000, 6'b000000}, // R3 full fill, clean
        {1'b0, 2'd0, 2'd1, 3'b111, 6'b000000, 6'b000001}, // R3 short fill, no end
        {1'b0, 2'd0, 2'd1, 3'b111, 6'b010000, 6'b000000}, // R3 short fill ending
        {1'b0, 2'd0, 2'd2, 3'b101, 6'b000000, 6'b000010}, // R4 mixed strobe
        {1'b0, 2'd0, 2'd2, 3'b111, 6'b000001, 6'b000100}, // R5 end on lane 0
        {1'b0, 2'd0, 2'd2, 3'b111, 6'b000100, 6'b000100}, // R5 end on lane 1
        {1'b0, 2'd0, 2'd2, 3'b111, 6'b100000, 6'b001000}, // R6 level 1 without 0
        {1'b0, 2'd0, 2'd2, 3'b000, 6'b100000, 6'b000000}, // R6 empty outer exempt
        {1'b1, 2'd0, 2'd2, 3'b000, 6'b100000, 6'b001000}, // R6 not empty when open
        {1'b0, 2'd0, 2'd2, 3'b000, 6'b010000, 6'b000000}, // R7 empty sequence
        {1'b1, 2'd0, 2'd2, 3'b000, 6'b010000, 6'b010000}, // R7 postponed end
        {1'b0, 2'd0, 2'd3, 3'b111, 6'b000000, 6'b100001}, // R8 endi beyond lanes
        {1'b0, 2'd0, 2'd3, 3'b111, 6'b010000, 6'b100000}, // R8 endi beyond, ending
        {1'b0, 2'd0, 2'd3, 3'b000, 6'b000000, 6'b000000}, // R9 inactive ignores endi
        {1'b0, 2'd3, 2'd1, 3'b111, 6'b010000, 6'b000000}, // R10 stai pin ignored
        {1'b1, 2'd0, 2'd0, 3'b111, 6'b110000, 6'b000000}  // R6 both levels end
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        s_valid = 1'b0;
        s_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic xfer(input logic [1:0] st, input logic [1:0] en,
                        input logic [2:0] sb, input logic [5:0] la);
        @(negedge clk);
        s_stai = st; s_endi = en; s_strb = sb; s_last = la;
        s_valid = 1'b1; s_ready = 1'b1;
        @(negedge clk);
        s_valid = 1'b0; s_ready = 1'b0;
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2 reset state
        check("R2 reset flags", int'(err_flags), 0);
        check("R2 reset any", int'(err_any), 0);
        check("R11 reset xfer", int'(xfer_count), 0);
        check("R11 reset term", int'(term_count), 0);

        // Table walk, reset before each entry.
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            int exp_x;
            int exp_t;
            v = VEC[i];
            do_reset();
            if (v[19]) xfer(2'd0, 2'd2, 3'b111, 6'b000000);
            xfer(v[18:17], v[16:15], v[14:12], v[11:6]);
            exp_x = v[19] ? 2 : 1;
            exp_t = (v[6] | v[8] | v[10]) ? 1 : 0;
            check($sformatf("R3 R4 R5 R6 R7 R8 R9 R10 flags vector %0d", i),
                  int'(err_flags), int'(v[5:0]));
            check($sformatf("R2 err_any vector %0d", i), int'(err_any),
                  (v[5:0] != 0) ? 1 : 0);
            check($sformatf("R11 xfer vector %0d", i), int'(xfer_count), exp_x);
            check($sformatf("R11 term vector %0d", i), int'(term_count), exp_t);
        end

        // R1: stalled and idle cycles with bad data change nothing.
        do_reset();
        @(negedge clk);
        s_stai = 2'd0; s_endi = 2'd3; s_strb = 3'b101; s_last = 6'b000011;
        s_valid = 1'b1; s_ready = 1'b0;
        @(negedge clk);
        s_valid = 1'b0; s_ready = 1'b1;
        @(negedge clk);
        s_ready = 1'b0;
        check("R1 stalled flags", int'(err_flags), 0);
        check("R1 stalled xfer", int'(xfer_count), 0);
        check("R1 stalled term", int'(term_count), 0);

        // R2: flag persists across clean transfers.
        xfer(2'd0, 2'd2, 3'b101, 6'b000000);
        xfer(2'd0, 2'd2, 3'b111, 6'b000000);
        xfer(2'd0, 2'd2, 3'b111, 6'b010000);
        check("R2 sticky flag", int'(err_flags), 6'b000010);
        check("R2 sticky any", int'(err_any), 1);
        check("R11 three xfers", int'(xfer_count), 3);
        check("R11 one term", int'(term_count), 1);

        // R7: termination closes the sequence, so a following empty one is legal.
        do_reset();
        xfer(2'd0, 2'd2, 3'b111, 6'b000000);
        xfer(2'd0, 2'd1, 3'b111, 6'b010000);
        xfer(2'd0, 2'd2, 3'b000, 6'b010000);
        check("R7 empty after close", int'(err_flags), 0);
        check("R11 two terms", int'(term_count), 2);

        // R2: reset clears sticky flags.
        xfer(2'd0, 2'd3, 3'b111, 6'b000000);
        do_reset();
        check("R2 flags cleared", int'(err_flags), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule